// File: doc/BRIEF.md
# CAN Bitwise Arbitration Unit

This block is the transmit-side arbitration logic of a CAN-style node. A start request loads an 11-bit identifier and a remote-request flag. The block then sends the arbitration field of a standard frame onto its transmit line, one bit per bit-time sample strobe. At every sample point it reads the wired-AND bus level back and compares it with the level it drives. From that comparison it decides whether the node keeps the bus or withdraws.

Logic 0 is dominant and logic 1 is recessive, so a numerically lower identifier wins. When two nodes share an identifier, the data frame (request bit 0) beats the remote frame (request bit 1). A node that loses raises a one-clock loss pulse with the field position of the loss, and its transmit line goes recessive straight away. A node that gets through the whole field raises a one-clock win pulse and hands over to the rest of the frame logic. Bit timing, stuffing, CRC, the data field and error counting sit outside this block.

Top module: `can_arb_unit`

## Requirements
- R1: After reset, `tx_o` is 1 (recessive) and `won_o`, `lost_o`, `bit_err_o` are 0, `lost_idx_o` is 0.
- R2: A `start_i` pulse while idle starts a frame. From the next clock, `tx_o` drives the first field bit until the next `strobe_i`.
- R3: The transmitted order is one bit per strobe: start-of-frame (0), identifier bits 10 down to 0, the request bit (`rtr_i`), then the extension bit (0).
- R4: At a strobe on a compared bit, if the node drives 1 and `rx_i` reads 0, `lost_o` pulses for one clock after that edge. `tx_o` is then 1 until a new start.
- R5: `lost_idx_o` encodes the loss position as 0 for identifier bit 10 up to 10 for identifier bit 0, and 11 for the request bit. It is loaded with each loss and held until the next one.
- R6: If the extension bit is sampled without loss or error, `won_o` pulses for one clock after that strobe and `tx_o` returns to 1. A lower identifier wins over a higher one, and for equal identifiers a request bit of 0 wins over 1.
- R7: At a strobe on a compared bit, if the node drives 0 and `rx_i` reads 1, `bit_err_o` pulses for one clock, `lost_o` stays 0, and the frame aborts with `tx_o` at 1.
- R8: The start-of-frame bit is never compared, so any `rx_i` level at its strobe raises no flag.
- R9: `start_i` is ignored while a frame is in progress. The bits already queued go out unchanged.
- R10: `tx_o` changes only on the clock edge that takes a strobe or a start.
- R11: At most one of `won_o`, `lost_o`, `bit_err_o` is high in any clock, each for a single clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin arbitration |
| id_i | input | 11 | Identifier, captured with the start request |
| rtr_i | input | 1 | Remote-request flag, captured with the start request |
| strobe_i | input | 1 | Bit-time sample point strobe |
| rx_i | input | 1 | Bus level read back |
| tx_o | output | 1 | Transmit line (0 dominant, 1 recessive) |
| won_o | output | 1 | One-clock pulse: arbitration won |
| lost_o | output | 1 | One-clock pulse: arbitration lost |
| lost_idx_o | output | 4 | Field position of the last loss |
| bit_err_o | output | 1 | One-clock pulse: drove dominant, read recessive |

## Verification
The assertions take for granted that `rx_i` has settled in the clock where `strobe_i` is high, and that a strobe is a single-clock pulse. They also assume that `id_i` and `rtr_i` matter only in the clock of an accepted start. The bench drives the bus read-back as the wired-AND of the node's own line and a modelled competitor, with an optional forced-recessive override for bit errors. It changes competitor levels and overrides only between strobes, so each strobe sees a settled bus. Identifiers and request flags are random from a fixed seed. Directed frames add equal identifiers, a start pulse during a frame, and disturbances on the start-of-frame and extension bits.

// File: rtl/can_arb_pkg.sv
package can_arb_pkg;

    localparam int ID_BITS   = 11;
    localparam int FIELD_LEN = ID_BITS + 3;            // SOF + ID + RTR + IDE
    localparam int POS_W     = $clog2(FIELD_LEN);
    localparam int IDX_W     = 4;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_ARB  = 1'b1
    } arb_state_e;

    typedef struct packed {
        logic             won;
        logic             lost;
        logic             bit_err;
        logic [IDX_W-1:0] idx;
    } arb_event_t;

    // Field image, first-sent bit at the MSB: SOF(0), ID MSB first, RTR, IDE(0).
    function automatic logic [FIELD_LEN-1:0] build_field(
        input logic [ID_BITS-1:0] id,
        input logic               rtr
    );
        return {1'b0, id, rtr, 1'b0};
    endfunction

endpackage

// File: rtl/can_arb_serializer.sv
module can_arb_serializer
    import can_arb_pkg::*;
#(
    parameter int LEN  = FIELD_LEN,
    parameter int PW   = POS_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           advance,
    input  logic [LEN-1:0] frame,
    output logic           cur_bit,
    output logic [PW-1:0]  pos
);

    logic [LEN-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '1;
            pos   <= '0;
        end else if (load) begin
            shreg <= frame;
            pos   <= '0;
        end else if (advance) begin
            shreg <= {shreg[LEN-2:0], 1'b1};
            pos   <= pos + 1'b1;
        end
    end

    assign cur_bit = shreg[LEN-1];

endmodule

// File: rtl/can_arb_judge.sv
module can_arb_judge
    import can_arb_pkg::*;
#(
    parameter int LEN = FIELD_LEN,
    parameter int PW  = POS_W
) (
    input  logic          active,
    input  logic          strobe,
    input  logic [PW-1:0] pos,
    input  logic          tx_bit,
    input  logic          rx_bit,
    output arb_event_t    ev,
    output logic          advance
);

    localparam logic [PW-1:0] LAST_POS = PW'(LEN - 1);

    always_comb begin
        ev      = '0;
        advance = 1'b0;
        if (active && strobe) begin
            if (pos == '0) begin
                advance = 1'b1;                 // SOF is not compared
            end else if (tx_bit && !rx_bit) begin
                ev.lost = 1'b1;
                ev.idx  = IDX_W'(pos - 1'b1);
            end else if (!tx_bit && rx_bit) begin
                ev.bit_err = 1'b1;
            end else if (pos == LAST_POS) begin
                ev.won = 1'b1;
            end else begin
                advance = 1'b1;
            end
        end
    end

endmodule

// File: rtl/can_arb_unit.sv
module can_arb_unit
    import can_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [ID_BITS-1:0] id_i,
    input  logic               rtr_i,
    input  logic               strobe_i,
    input  logic               rx_i,
    output logic               tx_o,
    output logic               won_o,
    output logic               lost_o,
    output logic [IDX_W-1:0]   lost_idx_o,
    output logic               bit_err_o
);

    arb_state_e           state;
    logic                 active;
    logic                 load;
    logic                 advance;
    logic                 cur_bit;
    logic [POS_W-1:0]     pos;
    arb_event_t           ev;

    assign active = (state == ST_ARB);
    assign load   = (state == ST_IDLE) && start_i;

    can_arb_serializer #(.LEN(FIELD_LEN), .PW(POS_W)) u_ser (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .advance (advance),
        .frame   (build_field(id_i, rtr_i)),
        .cur_bit (cur_bit),
        .pos     (pos)
    );

    can_arb_judge #(.LEN(FIELD_LEN), .PW(POS_W)) u_judge (
        .active  (active),
        .strobe  (strobe_i),
        .pos     (pos),
        .tx_bit  (cur_bit),
        .rx_bit  (rx_i),
        .ev      (ev),
        .advance (advance)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            won_o      <= 1'b0;
            lost_o     <= 1'b0;
            bit_err_o  <= 1'b0;
            lost_idx_o <= '0;
        end else begin
            won_o     <= ev.won;
            lost_o    <= ev.lost;
            bit_err_o <= ev.bit_err;
            if (ev.lost) lost_idx_o <= ev.idx;
            case (state)
                ST_IDLE: if (start_i) state <= ST_ARB;
                ST_ARB:  if (ev.won || ev.lost || ev.bit_err) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign tx_o = active ? cur_bit : 1'b1;

    AST_LOST_ON_RECESSIVE: assert property (@(posedge clk) disable iff (rst)
        lost_o |-> ($past(strobe_i) && $past(tx_o) && !$past(rx_i))); // R4

    AST_RELEASE_AFTER_LOSS: assert property (@(posedge clk) disable iff (rst)
        lost_o |-> tx_o); // R4

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        lost_o |-> (lost_idx_o <= IDX_W'(ID_BITS))); // R5

    AST_BITERR_ON_DOMINANT: assert property (@(posedge clk) disable iff (rst)
        bit_err_o |-> ($past(strobe_i) && !$past(tx_o) && $past(rx_i))); // R7

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        $onehot0({won_o, lost_o, bit_err_o})); // R11

    AST_WON_SINGLE: assert property (@(posedge clk) disable iff (rst)
        won_o |=> !won_o); // R11

    AST_TX_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (active && !strobe_i) |=> $stable(tx_o)); // R10

    AST_IGNORE_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        (active && start_i && !strobe_i) |=> (active && $stable(tx_o))); // R9

endmodule

// File: tb/can_arb_unit_tb.sv
module can_arb_unit_tb;
    import can_arb_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [10:0] id = '0;
    logic rtr = 1'b0;
    logic strobe = 1'b0;
    logic comp_lvl = 1'b1;
    logic force_rec = 1'b0;
    logic tx_w, rx_w, won_w, lost_w, berr_w;
    logic [3:0] idx_w;

    int checks = 0;
    int failures = 0;
    logic [3:0] last_idx = 4'd0;

    always #5 clk = ~clk;

    assign rx_w = force_rec ? 1'b1 : (tx_w & comp_lvl);

    can_arb_unit u_dut (
        .clk(clk), .rst(rst), .start_i(start), .id_i(id), .rtr_i(rtr),
        .strobe_i(strobe), .rx_i(rx_w), .tx_o(tx_w), .won_o(won_w),
        .lost_o(lost_w), .lost_idx_o(idx_w), .bit_err_o(berr_w)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [13:0] field_of(input logic [10:0] fid, input logic frtr);
        return {1'b0, fid, frtr, 1'b0};
    endfunction

    // Expected result at bit p: 0 none, 1 lost, 2 bit error, 3 won
    function automatic int expect_at(input int p, input logic own, input logic rxv);
        if (p == 0) return 0;
        if (own && !rxv) return 1;
        if (!own && rxv) return 2;
        if (p == 13) return 3;
        return 0;
    endfunction

    task automatic run_frame(input logic [10:0] fid, input logic frtr,
                             input bit use_comp, input logic [10:0] cid,
                             input logic crtr, input int err_pos, input bit poke);
        logic [13:0] own;
        logic [13:0] cmp;
        bit alive;
        bit done;
        own   = field_of(fid, frtr);
        cmp   = field_of(cid, crtr);
        alive = use_comp;
        done  = 0;
        @(negedge clk); start = 1'b1; id = fid; rtr = frtr;
        @(negedge clk); start = 1'b0; id = ~fid; rtr = ~frtr;
        for (int p = 0; p < 14 && !done; p++) begin
            logic own_b, rxv;
            int ex;
            comp_lvl  = alive ? cmp[13-p] : 1'b1;
            force_rec = (p == err_pos);
            if (poke && p == 5) begin
                start = 1'b1; id = 11'h7FF; rtr = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            own_b = own[13-p];
            chk(tx_w == own_b, "R3 tx bit order", tx_w, own_b);
            rxv = force_rec ? 1'b1 : (own_b & comp_lvl);
            ex  = expect_at(p, own_b, rxv);
            strobe = 1'b1;
            @(negedge clk);
            strobe = 1'b0;
            chk(lost_w == (ex == 1), "R4 lost pulse", lost_w, ex == 1);
            chk(berr_w == (ex == 2), "R7 bit error pulse", berr_w, ex == 2);
            chk(won_w  == (ex == 3), "R6 won pulse", won_w, ex == 3);
            if (p == 0)
                chk(!berr_w && !lost_w, "R8 SOF not compared", berr_w, 0);
            if (ex == 1) last_idx = 4'(p - 1);
            chk(idx_w == last_idx, "R5 loss index", idx_w, last_idx);
            if (alive && cmp[13-p] && !rxv) alive = 0;
            if (ex != 0) begin
                done = 1;
                chk(tx_w == 1'b1, "R4 tx released", tx_w, 1);
                @(negedge clk);
                chk(!won_w && !lost_w && !berr_w, "R11 single pulse",
                    {won_w, lost_w, berr_w}, 0);
            end
        end
        force_rec = 1'b0;
        comp_lvl  = 1'b1;
        chk(tx_w == 1'b1, "R6 tx idle after frame", tx_w, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_w == 1 && !won_w && !lost_w && !berr_w && idx_w == 0,
            "R1 reset state", {tx_w, won_w, lost_w, berr_w, idx_w}, 8'b1000_0000);

        // R10 / R2: idle with strobes and no start keeps line recessive
        strobe = 1'b1; @(negedge clk); strobe = 1'b0;
        chk(tx_w == 1'b1, "R10 idle strobe no tx change", tx_w, 1);
        @(negedge clk); start = 1'b1; id = 11'h000; rtr = 1'b0;
        @(negedge clk); start = 1'b0;
        chk(tx_w == 1'b0, "R2 SOF driven after start", tx_w, 0);
        repeat (3) @(negedge clk);
        chk(tx_w == 1'b0, "R10 tx holds without strobe", tx_w, 0);
        rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);

        // Directed cases
        run_frame(11'h123, 1'b0, 0, 11'h0,   1'b0, -1, 0); // R6 alone wins
        run_frame(11'h123, 1'b0, 1, 11'h122, 1'b0, -1, 0); // R4 lower id wins
        run_frame(11'h122, 1'b0, 1, 11'h123, 1'b0, -1, 0); // R6 we are lower
        run_frame(11'h2AA, 1'b1, 1, 11'h2AA, 1'b0, -1, 0); // R5 loss at RTR idx 11
        run_frame(11'h2AA, 1'b0, 1, 11'h2AA, 1'b1, -1, 0); // R6 data beats remote
        run_frame(11'h7FF, 1'b1, 1, 11'h3FF, 1'b1, -1, 0); // R5 loss at idx 0
        run_frame(11'h001, 1'b0, 1, 11'h000, 1'b0, -1, 0); // R5 loss at idx 10
        run_frame(11'h0F0, 1'b0, 0, 11'h0,   1'b0,  0, 0); // R8 SOF disturbed
        run_frame(11'h0F0, 1'b0, 0, 11'h0,   1'b0, 13, 0); // R7 IDE disturbed
        run_frame(11'h000, 1'b0, 0, 11'h0,   1'b0,  3, 0); // R7 id bit disturbed
        run_frame(11'h155, 1'b0, 0, 11'h0,   1'b0, -1, 1); // R9 start while busy

        // Random frames
        for (int n = 0; n < 60; n++) begin
            logic [10:0] a, b;
            logic ra, rb;
            bit uc;
            int ep;
            a  = 11'($urandom);
            ra = 1'($urandom);
            uc = ($urandom % 2) == 0;
            b  = (($urandom % 4) == 0) ? a : 11'($urandom);
            rb = 1'($urandom);
            ep = (($urandom % 8) == 0) ? int'($urandom % 14) : -1;
            run_frame(a, ra, uc, b, rb, ep, ($urandom % 6) == 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule